// File: doc/BRIEF.md
# Burst Address Counter Register

This block produces the word address for one port of a synchronous memory. On every rising clock edge it picks one of four actions for its internal address register: clear it to zero, take the address presented on the external address bus, step it by one, or keep it. The choice comes from three active-low controls sampled at the edge. Because the result is held in a register, the memory array sees a stable address for the whole following cycle.

The controls have a strict order of precedence. Clearing beats loading, loading beats stepping, and stepping beats holding. None of them depends on whether the port is selected. The port-enable input is accepted so that it can be wired alongside the other port controls, but the counter ignores it. A clear takes effect in a single edge and leaves no idle cycle: the cycle right after a clear already accesses address zero, and the following edge can load or step as usual. A one-cycle-delayed copy of the address is also provided, so that a neighbouring checker can compare it with the sequence it expects.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, `cur_addr` and `prev_addr` both become 0.
- R2: When `clear_n` is 0 at a rising edge, `cur_addr` becomes 0, whatever the values of `strobe_n`, `advance_n` and `ext_addr`.
- R3: When `clear_n` is 1 and `strobe_n` is 0 at a rising edge, `cur_addr` takes the value of `ext_addr`, whatever the value of `advance_n`.
- R4: When `clear_n` and `strobe_n` are 1 and `advance_n` is 0 at a rising edge, `cur_addr` becomes its previous value plus one.
- R5: When `clear_n`, `strobe_n` and `advance_n` are all 1 at a rising edge, `cur_addr` keeps its value and changes to `ext_addr` have no effect.
- R6: `port_en` has no effect: clearing, loading, stepping and holding behave the same with `port_en` at 0 as at 1.
- R7: Stepping from the all-ones address (0x1FFFF for the default 17-bit width) gives 0.
- R8: After every rising edge with `rst` low, `prev_addr` equals the value that `cur_addr` had before that edge.
- R9: A clear leaves no idle cycle: a load or step on the edge right after a clear acts on address 0 (for a step, the result is 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the address and its delayed copy |
| ext_addr | input | ADDR_W (17) | Address taken when the load strobe is active |
| strobe_n | input | 1 | Active-low load strobe |
| advance_n | input | 1 | Active-low count enable |
| clear_n | input | 1 | Active-low counter clear, highest precedence |
| port_en | input | 1 | Port select from the surrounding port; ignored by the counter |
| cur_addr | output | ADDR_W (17) | Registered internal address sent to the memory array |
| prev_addr | output | ADDR_W (17) | `cur_addr` delayed by one clock |

## Verification
The hardest case to reach from the ports is the wrap from the all-ones address. Stepping there from zero would take 131,071 edges. Instead, the stimulus loads 0x1FFFF through the strobe and then advances once, so the wrap happens within two cycles. The bench also drives all three controls low on the same edge to exercise precedence, and it follows a clear at once with a step to show that no cycle is lost. A long run of mixed control patterns, with `port_en` toggling throughout, is then compared edge by edge against a behavioural model that keeps its own address and delayed copy.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import burst_addr_pkg::*;
(
  input  logic     strobe_n,
  input  logic     advance_n,
  input  logic     clear_n,
  output addr_op_e op
);

  // Precedence: clear, then load, then step, then hold.
  always_comb begin
    if (!clear_n)        op = OP_CLEAR;
    else if (!strobe_n)  op = OP_LOAD;
    else if (!advance_n) op = OP_STEP;
    else                 op = OP_HOLD;
  end

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (op)
      OP_CLEAR: addr_d = '0;
      OP_LOAD:  addr_d = load_val;
      OP_STEP:  addr_d = addr_q + 1'b1;
      default:  addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  // R7: stepping from the top address wraps to zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP && addr_q == TOP_ADDR) |=> (addr_q == '0));

endmodule

// File: rtl/bac_delay.sv
module bac_delay #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= '0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              advance_n,
  input  logic              clear_n,
  input  logic              port_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] prev_addr
);

  addr_op_e op;

  bac_decode u_decode (
    .strobe_n  (strobe_n),
    .advance_n (advance_n),
    .clear_n   (clear_n),
    .op        (op)
  );

  bac_counter #(.ADDR_W(ADDR_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (ext_addr),
    .addr_q   (cur_addr)
  );

  bac_delay #(.WIDTH(ADDR_W), .DEPTH(1)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .din  (cur_addr),
    .dout (prev_addr)
  );

  // R2: clear wins over everything
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> (cur_addr == '0));

  // R3: strobe loads the external bus
  a_r3_load_ext: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !strobe_n) |=> (cur_addr == $past(ext_addr)));

  // R4: advance steps by one
  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (clear_n && strobe_n && !advance_n) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  // R5: idle controls hold the address
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clear_n && strobe_n && advance_n) |=> $stable(cur_addr));

  // R6: deselected port still steps
  a_r6_step_unselected: assert property (@(posedge clk) disable iff (rst)
    (!port_en && clear_n && strobe_n && !advance_n) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  // R8: delayed copy trails by one edge
  a_r8_prev_copy: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_addr == $past(cur_addr)));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 17;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          clear_n = 1'b1;
  logic          port_en = 1'b1;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] prev_addr;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  int m_cur  = 0;
  int m_prev = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .advance_n (advance_n),
    .clear_n   (clear_n),
    .port_en   (port_en),
    .cur_addr  (cur_addr),
    .prev_addr (prev_addr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%05h expected=%05h", req, what, act, exp);
    end
  endtask

  // Apply one set of inputs for one edge, update model, compare.
  task automatic step(input int ea, input bit s_n, input bit a_n, input bit c_n,
                      input bit pe, input bit r, input string req);
    @(negedge clk);
    ext_addr = ea[AW-1:0];
    strobe_n = s_n; advance_n = a_n; clear_n = c_n; port_en = pe; rst = r;
    @(posedge clk);
    if (r) begin
      m_cur = 0; m_prev = 0;
    end else begin
      m_prev = m_cur;
      if (!c_n)      m_cur = 0;
      else if (!s_n) m_cur = ea & MASK;
      else if (!a_n) m_cur = (m_cur + 1) & MASK;
    end
    #1;
    check(req, "cur_addr", int'(cur_addr), m_cur);
    check(r ? req : "R8", "prev_addr", int'(prev_addr), m_prev);
  endtask

  initial begin
    int lfsr;
    // R1: reset state
    step(32'h0AAAA, 0, 0, 1, 1, 1, "R1");
    step(32'h0AAAA, 0, 0, 1, 1, 1, "R1");
    // R3: load, strobe beats advance
    step(32'h1ABCD, 0, 0, 1, 1, 0, "R3");
    step(32'h00123, 0, 1, 1, 0, 0, "R3");
    // R4 and R6: steps with port deselected and selected
    step(32'h1FFFF, 1, 0, 1, 0, 0, "R6");
    step(32'h1FFFF, 1, 0, 1, 0, 0, "R6");
    step(32'h00000, 1, 0, 1, 1, 0, "R4");
    // R5: hold while external bus moves
    step(32'h15555, 1, 1, 1, 1, 0, "R5");
    step(32'h0AAAA, 1, 1, 1, 0, 0, "R5");
    // R2: clear beats load and advance
    step(32'h1F0F0, 0, 0, 0, 1, 0, "R2");
    // R9: step immediately after clear gives 1
    step(32'h1F0F0, 1, 0, 1, 1, 0, "R9");
    step(32'h00042, 1, 1, 0, 0, 0, "R2");
    step(32'h00077, 0, 1, 1, 1, 0, "R9");
    // R7: wrap from all ones
    step(32'h1FFFF, 0, 1, 1, 1, 0, "R3");
    step(32'h00000, 1, 0, 1, 1, 0, "R7");
    step(32'h00000, 1, 0, 1, 0, 0, "R4");
    // R1: mid-run reset overrides a load
    step(32'h12345, 0, 1, 1, 1, 1, "R1");
    step(32'h12345, 1, 0, 1, 1, 0, "R4");
    // Mixed patterns
    lfsr = 32'h1ACE1;
    for (int i = 0; i < 400; i++) begin
      bit s, a, c;
      string tag;
      lfsr = ((lfsr << 1) ^ (((lfsr >> 16) ^ (lfsr >> 13)) & 1)) & MASK;
      c = (lfsr % 11) != 0;
      s = (lfsr % 5) != 0;
      a = (lfsr % 3) == 0;
      if (!c)      tag = "R2";
      else if (!s) tag = "R3";
      else if (!a) tag = ((m_cur == MASK) ? "R7" : "R4");
      else         tag = "R5";
      step(lfsr ^ 32'h0F0F0, s, a, c, lfsr[0], 0, tag);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

endmodule